// File: doc/BRIEF.md
# One-Wire Bus Master Slot Generator

This block is the master on a single open-drain, wired-AND one-wire line. It makes one bus operation per command. A reset/presence cycle pulls the line low for a long time, releases it and samples whether any device holds the line low. A bit slot writes a 0, writes a 1, or reads one bit. Reading is done as a touch, which is a write-1 shaped slot that samples the line partway through. The block only pulls the line low through a drive enable. An external pull-up returns the line high. The line input passes through a two-flop synchroniser before it is used.

Slot timing is counted in microseconds. A parameter gives the number of clocks per microsecond. A per-command stretch coefficient then multiplies every delay in the slot. Each command ends with a one-cycle done pulse and a result bit. Byte assembly, device search and CRC are left to the logic around the block.

Top module: `onewire_slot_master`

## Requirements
- R1: The command encoding is `cmd_op_i` 00 = bus reset, 01 = write, 10 = touch, 11 = reserved. A command is taken on a rising clock edge where `cmd_valid_i` is high, `busy_o` is low and the op is not reserved.
- R2: Bus reset pulls the line low for 500 us and then releases it. It samples the line 70 us after release. It reports done 430 us after the sample, so the whole operation lasts 1000 us. `bit_o` is the sampled level: 1 means no device answered and 0 means presence.
- R3: A write with bit 0 pulls the line low for 60 us. The slot lasts 70 us in total and returns 0.
- R4: A write with bit 1 pulls the line low for 6 us. The slot lasts 70 us in total and returns 0.
- R5: A touch with bit 1 pulls the line low for 6 us. It samples the line 9 us after release and finishes 55 us later, 70 us in total. `bit_o` is the sampled level, so a device holding the line low only around that sample point gives 0.
- R6: A touch with bit 0 behaves as a write-0 slot and returns 0.
- R7: Every delay is multiplied by the coefficient `coef_i`, which is captured when the command is taken. A coefficient of 0 acts as 1. One microsecond is `CLKS_PER_US` clocks.
- R8: `busy_o` is high from the edge that takes the command until the edge that raises `done_o`. `done_o` is high for exactly one cycle, with `busy_o` low. A valid command presented while busy is ignored and does not change the running slot.
- R9: A reserved op (11) is ignored: `busy_o` and `pull_o` stay low.
- R10: The line is only ever pulled low, through `pull_o`, and only while `busy_o` is high. The line input is synchronised by two flops.
- R11: After reset, `busy_o`, `done_o`, `pull_o` and `bit_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | Operation: 00 reset, 01 write, 10 touch, 11 reserved |
| cmd_bit_i | input | 1 | Bit for a write or touch |
| coef_i | input | COEF_W | Timing stretch coefficient (0 acts as 1) |
| line_i | input | 1 | Asynchronous one-wire line level |
| pull_o | output | 1 | Drive-low enable for the open-drain line |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bit_o | output | 1 | Sampled result of the last operation |

## Verification
The bench counts pull-low cycles and total slot length for each slot shape at several coefficients, including 0. A design that scaled the wrong phase or mixed up the write-1 and write-0 shapes would show a wrong cycle count. A device model holds the line low only within a narrow window around 9 us after release. A touch that samples early or late would return 1 in place of 0. The bench also covers a second command arriving in the middle of a slot and a reserved op. A design that restarted its slot would stretch the slot length, and one that started on op 11 would raise busy.

// File: rtl/ow_pkg.sv
package ow_pkg;
  localparam int US_W = 10;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_TOUCH = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_REL, ST_TAIL} st_e;

  typedef struct packed {
    logic [US_W-1:0] low_us;
    logic [US_W-1:0] samp_us;
    logic [US_W-1:0] tail_us;
    logic            keep;
  } shape_t;

  // Bit-1 slots share one shape; write-0 sample point is a dummy split of its recovery.
  function automatic shape_t shape_of(input op_e op, input logic b);
    shape_t s;
    case (op)
      OP_RESET: s = '{low_us: US_W'(500), samp_us: US_W'(70), tail_us: US_W'(430), keep: 1'b1};
      default: begin
        if (b) s = '{low_us: US_W'(6),  samp_us: US_W'(9), tail_us: US_W'(55), keep: (op == OP_TOUCH)};
        else   s = '{low_us: US_W'(60), samp_us: US_W'(5), tail_us: US_W'(5),  keep: 1'b0};
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLKS_PER_US = 100,
  parameter int COEF_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              tick_o
);
  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

  logic [PRE_W-1:0]  pre_q;
  logic [COEF_W-1:0] rep_q, coef_q;
  logic              pre_wrap;

  assign pre_wrap = (pre_q == PRE_W'(CLKS_PER_US - 1));
  assign tick_o   = pre_wrap && (rep_q == coef_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      rep_q  <= '0;
      coef_q <= COEF_W'(1);
    end else if (restart_i) begin
      pre_q  <= '0;
      rep_q  <= '0;
      coef_q <= (coef_i == '0) ? COEF_W'(1) : coef_i;
    end else if (pre_wrap) begin
      pre_q <= '0;
      rep_q <= tick_o ? '0 : rep_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i && CLKS_PER_US > 1) |=> !tick_o); // R7
  AST_COEF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_q != '0); // R7
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
  import ow_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  input  logic bit_i,
  input  logic tick_i,
  input  logic line_i,
  output logic pull_o,
  output logic busy_o,
  output logic done_o,
  output logic bit_o
);
  st_e             st_q;
  shape_t          shp_q;
  logic [US_W-1:0] cnt_q;
  logic            done_q, bit_q;
  logic [US_W-1:0] limit;
  logic            phase_end;

  always_comb begin
    case (st_q)
      ST_LOW:  limit = shp_q.low_us;
      ST_REL:  limit = shp_q.samp_us;
      default: limit = shp_q.tail_us;
    endcase
  end

  assign phase_end = tick_i && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      shp_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        st_q  <= ST_LOW;
        shp_q <= shape_of(op_i, bit_i);
        cnt_q <= '0;
      end else if (st_q != ST_IDLE && tick_i) begin
        if (!phase_end) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          case (st_q)
            ST_LOW: st_q <= ST_REL;
            ST_REL: begin
              st_q  <= ST_TAIL;
              bit_q <= shp_q.keep ? line_i : 1'b0;
            end
            default: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign pull_o = (st_q == ST_LOW);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign bit_o  = bit_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == ST_IDLE)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> (st_q == $past(st_q))); // R7
  AST_LOW_THEN_REL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_o) |-> (st_q == ST_REL)); // R10
endmodule

// File: rtl/onewire_slot_master.sv
module onewire_slot_master #(
  parameter int CLKS_PER_US = 100,
  parameter int COEF_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_bit_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              line_i,
  output logic              pull_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              bit_o
);
  import ow_pkg::*;

  logic line_s, tick, start;
  op_e  op;

  assign op    = op_e'(cmd_op_i);
  assign start = cmd_valid_i && !busy_o && (op != OP_NONE);

  ow_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  ow_us_tick #(.CLKS_PER_US(CLKS_PER_US), .COEF_W(COEF_W)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(start),
    .coef_i   (coef_i),
    .tick_o   (tick)
  );

  ow_slot_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .op_i   (op),
    .bit_i  (cmd_bit_i),
    .tick_i (tick),
    .line_i (line_s),
    .pull_o (pull_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .bit_o  (bit_o)
  );

  AST_PULL_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_o |-> busy_o); // R10
  AST_RESERVED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'b11 && !busy_o) |=> !busy_o); // R9
  AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i != 2'b11 && !busy_o) |=> (busy_o && !done_o)); // R1
endmodule

// File: tb/onewire_slot_master_bench.sv
module onewire_slot_master_bench;
  localparam int C = 4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_bit = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [3:0] coef = 4'd1;
  logic       dev_low = 1'b0, win_en = 1'b0, win_low;
  logic       line, pull, busy, done, rbit;
  int         cyc = 0, rel_cnt = 0, checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rel_cnt <= pull ? 0 : rel_cnt + 1;
  assign win_low = win_en && busy && rel_cnt >= 8*C && rel_cnt < 10*C;
  assign line = !(pull || dev_low || win_low);

  onewire_slot_master #(.CLKS_PER_US(C), .COEF_W(4)) u_onewire_slot_master (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_bit_i(cmd_bit), .coef_i(coef), .line_i(line), .pull_o(pull),
    .busy_o(busy), .done_o(done), .bit_o(rbit));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void shape(input logic [1:0] op, input logic b,
                                output int lo, output int tot, output bit samp);
    if (op == 2'b00) begin lo = 500; tot = 1000; samp = 1; end
    else begin lo = b ? 6 : 60; tot = 70; samp = (op == 2'b10) && b; end
  endfunction

  // poke: offer a reset command mid-slot, which must be ignored
  task automatic run(input logic [1:0] op, input logic b, input logic [3:0] k,
                     input logic dl, input logic exp_bit, input bit poke, input string req);
    int lo, tot, n, t0, low_cyc, it;
    bit samp;
    shape(op, b, lo, tot, samp);
    n = C * ((k == 0) ? 1 : int'(k));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bit = b; coef = k; dev_low = dl;
    @(negedge clk);
    cmd_valid = 1'b0;
    t0 = cyc; low_cyc = 0; it = 0;
    while (!done && it < 20000) begin
      if (pull) low_cyc++;
      if (poke && it == 10) begin
        chk(busy, "R8 busy mid-slot", busy, 1);
        cmd_valid = 1'b1; cmd_op = 2'b00;
      end
      if (poke && it == 12) cmd_valid = 1'b0;
      it++;
      @(negedge clk);
    end
    if (it >= 20000) chk(0, "watchdog", it, tot * n);
    chk(low_cyc == lo * n, {req, " low time"}, low_cyc, lo * n);
    chk(cyc - t0 == tot * n, {req, " slot length"}, cyc - t0, tot * n);
    chk(rbit == exp_bit, {req, " result bit"}, rbit, exp_bit);
    chk(!busy, "R8 busy low at done", busy, 0);
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    dev_low = 1'b0;
  endtask

  initial begin
    int r;
    logic [1:0] op;
    logic b, dl, eb;
    logic [3:0] k;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pull && !rbit, "R11 reset state", {busy, done, pull, rbit}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(2'b00, 1'b0, 4'd1, 1'b0, 1'b1, 0, "R2 reset absent");
    run(2'b00, 1'b0, 4'd1, 1'b1, 1'b0, 0, "R2 reset present");
    run(2'b01, 1'b0, 4'd1, 1'b0, 1'b0, 0, "R3 write0");
    run(2'b01, 1'b1, 4'd1, 1'b1, 1'b0, 0, "R4 write1");
    run(2'b10, 1'b1, 4'd1, 1'b0, 1'b1, 0, "R5 touch high");
    run(2'b10, 1'b0, 4'd1, 1'b0, 1'b0, 0, "R6 touch0");
    run(2'b10, 1'b1, 4'd0, 1'b0, 1'b1, 0, "R7 coef zero");
    run(2'b10, 1'b1, 4'd3, 1'b0, 1'b1, 0, "R7 coef three");
    run(2'b10, 1'b1, 4'd1, 1'b0, 1'b1, 1, "R8 ignore while busy");
    win_en = 1'b1;
    run(2'b10, 1'b1, 4'd1, 1'b0, 1'b0, 0, "R5 sample window");
    win_en = 1'b0;

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!busy && !pull, "R9 reserved op", {busy, pull}, 0);
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R9 reserved stays idle", {busy, done}, 0);

    for (int i = 0; i < 24; i++) begin
      r  = $urandom;
      op = (r % 10 == 0) ? 2'b00 : ((r % 2 == 0) ? 2'b01 : 2'b10);
      b  = r[8];
      dl = r[9];
      k  = 4'(r[13:12]);
      if (op == 2'b00)      eb = !dl;
      else if (op == 2'b10) eb = b && !dl;
      else                  eb = 1'b0;
      run(op, b, k, dl, eb, 0, "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule